// File: doc/BRIEF.md
# Stack Pair Transfer Sequencer

This block moves 16-bit register pairs between a processor's register file and a byte-wide, single-port memory through a 16-bit stack pointer that it owns. It handles six commands: push a pair, pop a pair, swap a pair with the top two stack bytes, push a return address for a subroutine call, pop a return address, and load the stack pointer from a pair. Each memory access takes one clock. The stack grows toward lower addresses. A push stores the high byte first and a pop fetches the low byte first, so pushed data and popped data use the same byte layout.

The decoder presents a command for one cycle while `busy` is low. The push value carries the pair with the high register in bits 15:8 and the low register in bits 7:0. For the accumulator pair, the caller places the flag byte in the low half and the accumulator in the high half. The result of a pop or swap appears on `pop_val` in the cycle after `done` and stays there until the next pop or swap finishes. The memory returns read data in the cycle after the read strobe. A write takes effect at the clock edge that ends the strobe cycle.

Top module: `stack_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the unit returns to idle. Idle means `busy`, `done`, `mem_we` and `mem_re` low, `sp` equal to parameter `SP_RESET`, and `pop_val` zero.
- R2: Push, op code 1, runs two write cycles and pulses `done` in the second. The first cycle writes `push_val[15:8]` at SP-1. The second writes `push_val[7:0]` at SP-2. SP ends at SP-2.
- R3: Pop, op code 2, reads SP, then reads SP+1, then spends a third cycle with `done` high. SP ends at SP+2. From the next cycle, `pop_val` equals {byte at SP+1, byte at SP}.
- R4: Swap with top of stack, op code 3, runs four cycles. It reads SP, reads SP+1, writes `push_val[7:0]` at SP, then writes `push_val[15:8]` at SP+1 with `done` high. SP is unchanged, and from the next cycle `pop_val` holds the two old memory bytes.
- R5: Call push, op code 4, produces the same bus cycles as a push of `push_val`. Return pop, op code 5, produces the same bus cycles and result as a pop.
- R6: Load stack pointer, op code 6, takes one cycle with `done` high and no memory strobe. From the next cycle, `sp` equals {`push_val[15:8]`, `push_val[7:0]`}.
- R7: Stack pointer arithmetic wraps modulo 2^16 when it increments or decrements.
- R8: `done` is high for exactly one cycle per command. `busy` is high from the first working cycle through the `done` cycle.
- R9: While `busy` is high, `cmd_valid` and its operands have no effect on the running sequence.
- R10: Op codes 0 and 7 are ignored. They raise no `busy`, produce no strobe and do not change `sp`.
- R11: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present; accepted only while idle |
| cmd_op | input | 3 | Command code (1 push, 2 pop, 3 swap, 4 call, 5 return, 6 load SP) |
| push_val | input | 16 | Pair to push, swap or load; high register in 15:8 |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pop_val | output | 16 | Pair fetched by the last pop, return or swap |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| sp | output | 16 | Current stack pointer |

## Verification
The assertions assume that the memory answers a read in the very next cycle. They also assume that the op code and push value are stable in the cycle `cmd_valid` is sampled while idle, because the first-cycle checks compare against those sampled values. The bench models a memory with exactly that one-cycle read latency. It changes inputs only on falling edges and raises `cmd_valid` for a single cycle when the unit is idle. The exception is one deliberate run where it holds `cmd_valid` high with a conflicting command while the unit is busy, and drops it in the `done` cycle so that no second command slips in.

// File: rtl/stack_seq_pkg.sv
// Package: shared command codes and sequencer states for the stack pair
// transfer sequencer. Assumes a 3-bit command field.
package stack_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_XTOP = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5,
        OP_LDSP = 3'd6,
        OP_RSVD = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_HI,
        S_WR_LO,
        S_RD_LO,
        S_RD_HI,
        S_RD_END,
        S_XR_LO,
        S_XR_HI,
        S_XW_LO,
        S_XW_HI,
        S_LD
    } state_e;

endpackage

// File: rtl/stack_seq_ctrl.sv
// Module: sequencing state machine. Accepts a command only in S_IDLE and
// walks the fixed cycle pattern for that command, then returns to idle.
// Assumes cmd_op is stable while cmd_valid is high in an idle cycle.
module stack_seq_ctrl
    import stack_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output state_e     state,
    output logic       accept
);

    state_e state_nx;
    op_e    op;

    assign op = op_e'(cmd_op);

    // Decide the next state and whether a command is taken this cycle.
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    accept = 1'b1;
                    case (op)
                        OP_PUSH, OP_CALL: state_nx = S_WR_HI;
                        OP_POP,  OP_RET:  state_nx = S_RD_LO;
                        OP_XTOP:          state_nx = S_XR_LO;
                        OP_LDSP:          state_nx = S_LD;
                        default:          accept   = 1'b0;
                    endcase
                end
            end
            S_WR_HI:  state_nx = S_WR_LO;
            S_WR_LO:  state_nx = S_IDLE;
            S_RD_LO:  state_nx = S_RD_HI;
            S_RD_HI:  state_nx = S_RD_END;
            S_RD_END: state_nx = S_IDLE;
            S_XR_LO:  state_nx = S_XR_HI;
            S_XR_HI:  state_nx = S_XW_LO;
            S_XW_LO:  state_nx = S_XW_HI;
            S_XW_HI:  state_nx = S_IDLE;
            S_LD:     state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/stack_seq_ptr.sv
// Module: stack pointer register. Steps down or up by one, or loads a
// new value; arithmetic wraps at 2^ADDR_W. Assumes at most one of the
// three controls is high per cycle.
module stack_seq_ptr #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_dn,
    input  logic              step_up,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_dn,
    output logic [ADDR_W-1:0] sp_up
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Neighbouring addresses, wrapping naturally in ADDR_W bits.
    always_comb begin
        sp_dn = sp - ONE;
        sp_up = sp + ONE;
    end

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       sp <= SP_RESET;
        else if (load)    sp <= load_val;
        else if (step_dn) sp <= sp_dn;
        else if (step_up) sp <= sp_up;
    end

endmodule

// File: rtl/stack_seq_path.sv
// Module: datapath. Latches the pair at command acceptance, drives the
// memory bus from the current state and assembles fetched bytes into the
// result pair. Assumes read data arrives the cycle after the read strobe.
module stack_seq_path
    import stack_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    localparam int PAIR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  state_e            state,
    input  logic              accept,
    input  logic [PAIR_W-1:0] push_val,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] sp_dn,
    input  logic [ADDR_W-1:0] sp_up,
    output logic [PAIR_W-1:0] hold_val,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PAIR_W-1:0] pop_val,
    output logic              done,
    output logic              busy
);

    logic [BYTE_W-1:0] hold_hi, hold_lo;
    logic [BYTE_W-1:0] cap_lo, cap_hi;

    assign hold_hi = hold_val[PAIR_W-1:BYTE_W];
    assign hold_lo = hold_val[BYTE_W-1:0];

    // Capture the operand pair when a command is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_val <= '0;
        else if (accept) hold_val <= push_val;
    end

    // Bus drive per state: address, data and strobes.
    always_comb begin
        mem_addr  = sp;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        unique case (state)
            S_WR_HI: begin mem_addr = sp_dn; mem_we = 1'b1; mem_wdata = hold_hi; end
            S_WR_LO: begin mem_addr = sp_dn; mem_we = 1'b1; mem_wdata = hold_lo; end
            S_RD_LO: begin mem_addr = sp;    mem_re = 1'b1; end
            S_RD_HI: begin mem_addr = sp;    mem_re = 1'b1; end
            S_XR_LO: begin mem_addr = sp;    mem_re = 1'b1; end
            S_XR_HI: begin mem_addr = sp_up; mem_re = 1'b1; end
            S_XW_LO: begin mem_addr = sp;    mem_we = 1'b1; mem_wdata = hold_lo; end
            S_XW_HI: begin mem_addr = sp_up; mem_we = 1'b1; mem_wdata = hold_hi; end
            default: ;
        endcase
    end

    // Completion and activity flags.
    always_comb begin
        done = (state == S_WR_LO) || (state == S_RD_END) ||
               (state == S_XW_HI) || (state == S_LD);
        busy = (state != S_IDLE);
    end

    // Collect returned bytes; the low byte returns first in both flows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_lo <= '0;
            cap_hi <= '0;
        end else begin
            if (state == S_RD_HI || state == S_XR_HI) cap_lo <= mem_rdata;
            if (state == S_XW_LO)                     cap_hi <= mem_rdata;
        end
    end

    // Publish the result pair at the end of the done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pop_val <= '0;
        else if (state == S_RD_END) pop_val <= {mem_rdata, cap_lo};
        else if (state == S_XW_HI)  pop_val <= {cap_hi, cap_lo};
    end

endmodule

// File: rtl/stack_seq.sv
// Module: top of the stack pair transfer sequencer. Joins the state
// machine, the stack pointer and the datapath. Assumes a single-port
// byte memory with one-cycle read latency and same-edge writes.
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                BYTE_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = '0,
    localparam int               PAIR_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [PAIR_W-1:0] push_val,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PAIR_W-1:0] pop_val,
    output logic              done,
    output logic              busy,
    output logic [ADDR_W-1:0] sp
);

    state_e            state;
    logic              accept;
    logic [ADDR_W-1:0] sp_dn, sp_up;
    logic [PAIR_W-1:0] hold_val;
    logic              step_dn, step_up, load_sp;
    logic [ADDR_W-1:0] load_val;

    // Pointer controls derived from the current step.
    always_comb begin
        step_dn  = (state == S_WR_HI) || (state == S_WR_LO);
        step_up  = (state == S_RD_LO) || (state == S_RD_HI);
        load_sp  = (state == S_LD);
        load_val = ADDR_W'(hold_val);
    end

    stack_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .state     (state),
        .accept    (accept)
    );

    stack_seq_ptr #(
        .ADDR_W   (ADDR_W),
        .SP_RESET (SP_RESET)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_dn  (step_dn),
        .step_up  (step_up),
        .load     (load_sp),
        .load_val (load_val),
        .sp       (sp),
        .sp_dn    (sp_dn),
        .sp_up    (sp_up)
    );

    stack_seq_path #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .push_val  (push_val),
        .mem_rdata (mem_rdata),
        .sp        (sp),
        .sp_dn     (sp_dn),
        .sp_up     (sp_up),
        .hold_val  (hold_val),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .pop_val   (pop_val),
        .done      (done),
        .busy      (busy)
    );

endmodule

// File: rtl/stack_seq_chk.sv
// Module: port-level property checker for stack_seq, attached by bind.
// Assumes op code and push value are stable in an accepted cycle.
module stack_seq_chk
    import stack_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    localparam int PAIR_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [PAIR_W-1:0] push_val,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              mem_re,
    input logic              done,
    input logic              busy,
    input logic [ADDR_W-1:0] sp
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              take;
    logic              x_pend;
    logic [ADDR_W-1:0] x_sp;

    assign take = cmd_valid && !busy;

    // Remember the pointer at the start of a swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_pend <= 1'b0;
            x_sp   <= '0;
        end else if (take && cmd_op == OP_XTOP) begin
            x_pend <= 1'b1;
            x_sp   <= sp;
        end else if (done) begin
            x_pend <= 1'b0;
        end
    end

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !done));

    p_sp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done) |-> (sp == $past(sp) || sp == $past(sp) + ONE ||
                          sp == $past(sp) - ONE));

    p_push_first_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd_op == OP_PUSH || cmd_op == OP_CALL)) |=>
        (mem_we && mem_addr == $past(sp) - ONE &&
         mem_wdata == $past(push_val[PAIR_W-1:BYTE_W])));

    p_pop_first_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd_op == OP_POP || cmd_op == OP_RET)) |=>
        (mem_re && mem_addr == $past(sp)));

    p_xtop_keep_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && x_pend) |-> (sp == x_sp));

    p_ldsp_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_LDSP) |=> (done && !mem_we && !mem_re));

endmodule

bind stack_seq stack_seq_chk #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .push_val  (push_val),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .done      (done),
    .busy      (busy),
    .sp        (sp)
);

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
// Bench: behavioural model with an expected-cycle queue and a byte memory,
// compared against the unit on every falling edge.
module stack_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] push_val = 16'h0;
    logic [7:0]  mem_rdata = 8'h0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [15:0] pop_val;
    logic        done, busy;
    logic [15:0] sp;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stack_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .push_val(push_val), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .pop_val(pop_val), .done(done), .busy(busy), .sp(sp)
    );

    // Byte memory: writes at the edge, reads return one cycle later.
    logic [7:0] mem [logic [15:0]];
    function automatic logic [7:0] mget(logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] = mem_wdata;
        if (mem_re) mem_rdata <= mget(mem_addr);
    end

    typedef struct {
        bit          we, re, dn, upd;
        logic [15:0] addr, spv, pnew;
        logic [7:0]  wd;
        int          req;
    } exp_t;

    exp_t        q[$];
    logic [15:0] m_sp;
    logic [15:0] m_pop;
    int          idle_req = 10;

    task automatic chk(bit ok, int req, string what, logic [15:0] act, logic [15:0] ex);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h at %0t", req, what, act, ex, $time);
        end
    endtask

    // Compare one cycle of outputs with the model, then advance the model.
    task automatic tick();
        exp_t e;
        bit   active;
        @(negedge clk);
        active = (q.size() > 0);
        if (active) e = q.pop_front();
        else begin
            e = '{we:0, re:0, dn:0, upd:0, addr:16'h0, spv:m_sp, pnew:16'h0, wd:8'h0, req:idle_req};
        end
        chk(busy == active, active ? 8 : e.req, "busy", {15'h0, busy}, {15'h0, active});    // R8
        chk(done == e.dn, active ? 8 : e.req, "done", {15'h0, done}, {15'h0, e.dn});
        chk(!(mem_we && mem_re), 11, "strobe overlap", {14'h0, mem_we, mem_re}, 16'h0);  // R11
        chk(mem_we == e.we, e.req, "mem_we", {15'h0, mem_we}, {15'h0, e.we});
        chk(mem_re == e.re, e.req, "mem_re", {15'h0, mem_re}, {15'h0, e.re});
        if (e.we || e.re) chk(mem_addr == e.addr, e.req, "mem_addr", mem_addr, e.addr);
        if (e.we) chk(mem_wdata == e.wd, e.req, "mem_wdata", {8'h0, mem_wdata}, {8'h0, e.wd});
        chk(sp == e.spv, e.req, "sp", sp, e.spv);
        chk(pop_val == m_pop, e.req, "pop_val", pop_val, m_pop);
        if (e.upd) m_pop = e.pnew;
    endtask

    function automatic exp_t mk(bit we, bit re, logic [15:0] a, logic [7:0] wd,
                                logic [15:0] s, bit dn, int req);
        exp_t e;
        e = '{we:we, re:re, dn:dn, upd:0, addr:a, spv:s, pnew:16'h0, wd:wd, req:req};
        return e;
    endfunction

    // Enqueue the expected cycles for a command and drive it for one cycle.
    // With noise set, cmd_valid stays high with another command while busy (R9).
    task automatic issue(logic [2:0] op, logic [15:0] v, int req, bit noise);
        logic [15:0] s;
        exp_t        e;
        s = m_sp;
        cmd_valid = 1'b1; cmd_op = op; push_val = v;
        case (op)
            3'd1, 3'd4: begin // R2 push, R5 call
                q.push_back(mk(1, 0, s - 16'd1, v[15:8], s, 0, req));
                q.push_back(mk(1, 0, s - 16'd2, v[7:0], s - 16'd1, 1, req));
                m_sp = s - 16'd2;
            end
            3'd2, 3'd5: begin // R3 pop, R5 return
                q.push_back(mk(0, 1, s, 8'h0, s, 0, req));
                q.push_back(mk(0, 1, s + 16'd1, 8'h0, s + 16'd1, 0, req));
                e = mk(0, 0, 16'h0, 8'h0, s + 16'd2, 1, req);
                e.upd = 1; e.pnew = {mget(s + 16'd1), mget(s)};
                q.push_back(e);
                m_sp = s + 16'd2;
            end
            3'd3: begin // R4 swap
                q.push_back(mk(0, 1, s, 8'h0, s, 0, req));
                q.push_back(mk(0, 1, s + 16'd1, 8'h0, s, 0, req));
                q.push_back(mk(1, 0, s, v[7:0], s, 0, req));
                e = mk(1, 0, s + 16'd1, v[15:8], s, 1, req);
                e.upd = 1; e.pnew = {mget(s + 16'd1), mget(s)};
                q.push_back(e);
            end
            3'd6: begin // R6 load SP
                q.push_back(mk(0, 0, 16'h0, 8'h0, s, 1, req));
                m_sp = v;
            end
            default: idle_req = 10; // R10 ignored codes
        endcase
        tick();
        if (noise) begin
            cmd_op = 3'd6; push_val = 16'hDEAD;
        end else begin
            cmd_valid = 1'b0;
        end
        while (q.size() > 0) begin
            tick();
            if (q.size() == 0) cmd_valid = 1'b0;
        end
        cmd_valid = 1'b0;
        tick();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            finished = 1'b1;
            $finish;
        end
    end

    initial begin
        m_sp = 16'h0000; m_pop = 16'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_we && !mem_re, 1, "idle flags",
            {12'h0, busy, done, mem_we, mem_re}, 16'h0);
        chk(sp == 16'h0000, 1, "reset sp", sp, 16'h0000);
        chk(pop_val == 16'h0, 1, "reset pop_val", pop_val, 16'h0);
        rst_n = 1'b1;
        tick();
        issue(3'd1, 16'h1234, 2, 0);   // R2 push, R7 wrap below zero
        issue(3'd4, 16'hABCD, 5, 0);   // R5 call push
        issue(3'd2, 16'h0000, 3, 0);   // R3 pop returns ABCD
        issue(3'd3, 16'h5566, 4, 0);   // R4 swap, old 1234 returned
        issue(3'd5, 16'h0000, 5, 0);   // R5 return, R7 wrap above FFFF
        issue(3'd6, 16'h2000, 6, 0);   // R6 load SP
        issue(3'd1, 16'hA55A, 9, 1);   // R9 conflicting command held while busy
        issue(3'd7, 16'h7777, 10, 0);  // R10 reserved code ignored
        issue(3'd0, 16'h1111, 10, 0);  // R10 no-op code ignored
        issue(3'd2, 16'h0000, 9, 0);   // R9 pushed value survived intact
        issue(3'd6, 16'hFFFF, 6, 0);   // R6 load SP near top
        issue(3'd2, 16'h0000, 7, 0);   // R7 pop across wrap
        issue(3'd3, 16'h0F0E, 4, 0);   // R4 swap at wrapped pointer
        issue(3'd3, 16'h9988, 4, 0);   // R4 swap returns previous pair
        issue(3'd1, 16'h00FF, 2, 0);   // R2 push
        issue(3'd5, 16'h0000, 5, 0);   // R5 return pops it back
        repeat (3) tick();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule